// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Pacing

This block sits between a register bus and an audio serializer. It holds one 64-word queue for playback samples and one for capture samples. Software or a DMA engine fills the playback queue and empties the capture queue through a single data register. The serializer drains and fills the queues through a simple pop and push strobe interface, and it only has effect while the block is enabled, out of standby and turned on for that direction.

A control/status register combines the enables, the queue flush requests, a sync echo bit, live status flags and two sticky error flags. Flushes and the sync echo are timed by a serial-clock strobe. A flush completes, and a written sync value becomes visible, only on the second strobe after the write, so software can poll the echo bit to learn that a flush has finished. A separate level register holds four 7-bit levels. The block compares the queue levels against these levels to raise a normal DMA request and a more urgent panic request for each direction.

Top module: `pcm_fifo_dma`

## Requirements
- R1: After reset the control register reads 0x00220000 (only bit 21 and bit 17 set), the level register reads 0x10303020, and all four DMA outputs are low.
- R2: With bits 0 (enable), 25 (leave standby) and 2 (playback on) set, words written to address 1 leave on `tx_word` in write order, one per `tx_pop`. With bits 0, 25 and 1 (capture on) set, words given with `rx_push` are returned in order by reads of address 1.
- R3: Each queue holds 64 words. A bus write to a full playback queue is dropped, and a bus read of an empty capture queue returns zero and changes nothing.
- R4: A `tx_pop` accepted while the playback queue is empty sets bit 15, and an `rx_push` accepted while the capture queue is full sets bit 16. Both flags stay set until a control write with a 1 in that bit position.
- R5: The control register reads status as follows: bit 21 = playback queue empty, bit 20 = capture queue not empty, bit 17 = playback level below the playback request level, bit 18 = capture level above the capture request level.
- R6: With bit 9 set, `tx_dreq` is high while the playback level is below level-register bits [14:8], and `rx_dreq` is high while the capture level is above bits [6:0]. With bit 9 clear, all four DMA outputs are low.
- R7: With bit 9 set, `tx_panic` is high while the playback level is below bits [30:24], and `rx_panic` is high while the capture level is above bits [22:16].
- R8: A control write with bit 3 (playback) or bit 4 (capture) set empties that queue at the second `ser_tick` after the write cycle. A tick in the write cycle itself does not count. While the flush is pending, the same bit reads 1.
- R9: The value written to bit 24 reads back in bit 24 only after two `ser_tick` strobes that follow the write cycle.
- R10: When the enable, standby-exit or direction bit is clear, `tx_pop` removes nothing and sets no error, and `rx_push` stores nothing and sets no error.
- R11: Address 2 is the level register. It is read/write, and bits 31, 23, 15 and 7 always read 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 1 pops the capture queue) |
| bus_addr | input | 2 | Register select: 0 control, 1 data, 2 levels |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the same cycle |
| ser_tick | input | 1 | One pulse per serial clock cycle |
| tx_pop | input | 1 | Serializer takes the playback word |
| tx_word | output | 32 | Head of the playback queue, zero when it is empty |
| rx_push | input | 1 | Serializer delivers a capture word |
| rx_word | input | 32 | Capture word |
| tx_dreq | output | 1 | Playback DMA request |
| tx_panic | output | 1 | Playback urgent request |
| rx_dreq | output | 1 | Capture DMA request |
| rx_panic | output | 1 | Capture urgent request |

## Verification
The assertions check on every cycle that the queue level holds when a push meets a full queue or a pop meets an empty queue, and that a flush leaves the level at zero. They also check that the sync echo moves only on a tick, that the error flags stay set until a write-one clear, and that the DMA outputs are quiet while DMA is disabled. Whether stored word order survives a mixture of pushes, pops and drops can only be shown by the bench, which compares against its own queue model. The same holds for the exact tick on which a flush or echo lands, and for how the request outputs track thresholds that are rewritten at random.

// File: rtl/pcmq_pkg.sv
// Shared constants for the audio sample FIFO pair.
// Assumes a 32-bit register bus with a 2-bit word address.
package pcmq_pkg;
    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_DATA = 2'd1,
        ADDR_LVL  = 2'd2,
        ADDR_NONE = 2'd3
    } pcmq_addr_e;

    // Control/status bit positions (software decodes these).
    localparam int B_EN     = 0;
    localparam int B_RXON   = 1;
    localparam int B_TXON   = 2;
    localparam int B_TXCLR  = 3;
    localparam int B_RXCLR  = 4;
    localparam int B_DMAEN  = 9;
    localparam int B_TXERR  = 15;
    localparam int B_RXERR  = 16;
    localparam int B_TXW    = 17;
    localparam int B_RXR    = 18;
    localparam int B_RXD    = 20;
    localparam int B_TXE    = 21;
    localparam int B_SYNC   = 24;
    localparam int B_WAKE   = 25;

    // Level register: four 7-bit fields.
    localparam int          THR_W     = 7;
    localparam logic [31:0] LVL_MASK  = 32'h7F7F_7F7F;
    localparam logic [31:0] LVL_RESET = 32'h1030_3020;
endpackage

// File: rtl/pcmq_fifo.sv
// Synchronous word FIFO with an occupancy count.
// Does: stores up to DEPTH words; drops a push when full and a pop when
// empty; a flush (clr) wins over push and pop in the same cycle.
// Assumes: DEPTH is a power of two; dout is zero while empty.
module pcmq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = empty ? '0 : mem[rptr];

    // Pointer and level bookkeeping, flush has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Storage write; no reset needed since reads are masked while empty.
    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wptr] <= din;
    end

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (level == LW'(DEPTH)));

    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> empty);

    // R8
    flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0));

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop && !clr) |=> $stable(level));
endmodule

// File: rtl/pcmq_settle.sv
// Serial-clock timed flush and sync echo.
// Does: a flush request loads a countdown of DELAY serial ticks; the flush
// fires on the tick that ends the countdown. The sync value written by
// software shifts through DELAY tick-clocked stages before it is echoed.
// Assumes: tick is a one-cycle strobe per serial clock; a tick in the
// cycle of a request is not counted.
module pcmq_settle #(
    parameter int DELAY = 2,
    parameter int NCLR  = 2,
    localparam int CW   = $clog2(DELAY + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NCLR-1:0] clr_req,
    output logic [NCLR-1:0] clr_fire,
    output logic [NCLR-1:0] clr_busy,
    input  logic            sync_wr,
    input  logic            sync_din,
    output logic            sync_echo
);
    generate
        for (genvar g = 0; g < NCLR; g++) begin : g_clr
            logic [CW-1:0] cnt_q;

            // Countdown of serial ticks until the flush lands.
            always_ff @(posedge clk) begin
                if (!rst_n)                      cnt_q <= '0;
                else if (clr_req[g])             cnt_q <= CW'(DELAY);
                else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
            end

            assign clr_busy[g] = (cnt_q != '0);
            assign clr_fire[g] = tick && (cnt_q == CW'(1)) && !clr_req[g];

            // R8
            flush_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clr_req[g] |=> clr_busy[g]);
        end
    endgenerate

    logic             sync_q;
    logic [DELAY-1:0] stage_q;

    // Software-side sync value, captured on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       sync_q <= 1'b0;
        else if (sync_wr) sync_q <= sync_din;
    end

    // Tick-clocked delay line for the echo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (tick) begin
            stage_q[0] <= sync_q;
            for (int i = 1; i < DELAY; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_echo = stage_q[DELAY-1];

    // R9
    echo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sync_echo));
endmodule

// File: rtl/pcmq_dreq.sv
// DMA pacing comparators.
// Does: compares the playback level against its request and panic levels
// (below = needs data) and the capture level against its levels
// (above = needs draining). Outputs are gated by the DMA enable; the
// ungated request compares also feed the status flags.
// Assumes: levels and thresholds are unsigned.
module pcmq_dreq #(
    parameter int LW   = 7,
    parameter int TW   = 7,
    localparam int CMPW = ((LW > TW) ? LW : TW) + 1
) (
    input  logic          dma_en,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic [TW-1:0] tx_req_lvl,
    input  logic [TW-1:0] tx_pnc_lvl,
    input  logic [TW-1:0] rx_req_lvl,
    input  logic [TW-1:0] rx_pnc_lvl,
    output logic          tx_need,
    output logic          rx_need,
    output logic          tx_dreq,
    output logic          tx_panic,
    output logic          rx_dreq,
    output logic          rx_panic
);
    logic [TW-1:0] tx_thr [2];
    logic [TW-1:0] rx_thr [2];
    logic [1:0]    tx_below;
    logic [1:0]    rx_above;

    assign tx_thr[0] = tx_req_lvl;
    assign tx_thr[1] = tx_pnc_lvl;
    assign rx_thr[0] = rx_req_lvl;
    assign rx_thr[1] = rx_pnc_lvl;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_cmp
            assign tx_below[g] = CMPW'(tx_level) < CMPW'(tx_thr[g]);
            assign rx_above[g] = CMPW'(rx_level) > CMPW'(rx_thr[g]);
        end
    endgenerate

    assign tx_need  = tx_below[0];
    assign rx_need  = rx_above[0];
    assign tx_dreq  = dma_en && tx_below[0];
    assign tx_panic = dma_en && tx_below[1];
    assign rx_dreq  = dma_en && rx_above[0];
    assign rx_panic = dma_en && rx_above[1];
endmodule

// File: rtl/pcm_fifo_dma.sv
// Audio sample FIFO pair with register access and DMA pacing.
// Does: one playback and one capture FIFO, a control/status register,
// a level register, serial-clock timed flushes and sync echo, sticky
// underflow/overflow flags and four DMA request outputs.
// Assumes: one bus access per cycle; bus_rdata is combinational and a
// read of the data address pops the capture FIFO at the clock edge.
module pcm_fifo_dma #(
    parameter int WIDTH       = 32,
    parameter int DEPTH       = 64,
    parameter int SETTLE_TICK = 2,
    localparam int LW         = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             ser_tick,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_word,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_word,
    output logic             tx_dreq,
    output logic             tx_panic,
    output logic             rx_dreq,
    output logic             rx_panic
);
    import pcmq_pkg::*;

    logic        en_q, rxon_q, txon_q, dmaen_q, wake_q;
    logic        txerr_q, rxerr_q;
    logic [31:0] lvl_q;

    logic        wr_ctrl, wr_data, wr_lvl, rd_data;
    logic        tx_live, rx_live;
    logic        tx_uflow, rx_oflow;
    logic [1:0]  clr_req, clr_fire, clr_busy;
    logic        sync_echo;

    logic [WIDTH-1:0] rx_head;
    logic [LW-1:0]    tx_level, rx_level;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_need, rx_need;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
    assign wr_lvl  = bus_wr && (bus_addr == ADDR_LVL);
    assign rd_data = bus_rd && (bus_addr == ADDR_DATA);

    assign tx_live  = en_q && wake_q && txon_q;
    assign rx_live  = en_q && wake_q && rxon_q;
    assign tx_uflow = tx_pop && tx_live && tx_empty;
    assign rx_oflow = rx_push && rx_live && rx_full;

    assign clr_req[0] = wr_ctrl && bus_wdata[B_TXCLR];
    assign clr_req[1] = wr_ctrl && bus_wdata[B_RXCLR];

    // Control bits held by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rxon_q  <= 1'b0;
            txon_q  <= 1'b0;
            dmaen_q <= 1'b0;
            wake_q  <= 1'b0;
        end else if (wr_ctrl) begin
            en_q    <= bus_wdata[B_EN];
            rxon_q  <= bus_wdata[B_RXON];
            txon_q  <= bus_wdata[B_TXON];
            dmaen_q <= bus_wdata[B_DMAEN];
            wake_q  <= bus_wdata[B_WAKE];
        end
    end

    // Sticky error flags: a new event wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txerr_q <= 1'b0;
            rxerr_q <= 1'b0;
        end else begin
            if (tx_uflow)                              txerr_q <= 1'b1;
            else if (wr_ctrl && bus_wdata[B_TXERR])    txerr_q <= 1'b0;
            if (rx_oflow)                              rxerr_q <= 1'b1;
            else if (wr_ctrl && bus_wdata[B_RXERR])    rxerr_q <= 1'b0;
        end
    end

    // Level register; unused bits are held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      lvl_q <= LVL_RESET;
        else if (wr_lvl) lvl_q <= bus_wdata & LVL_MASK;
    end

    pcmq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_fire[0]),
        .push  (wr_data),
        .din   (bus_wdata[WIDTH-1:0]),
        .pop   (tx_pop && tx_live),
        .dout  (tx_word),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    pcmq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_fire[1]),
        .push  (rx_push && rx_live),
        .din   (rx_word),
        .pop   (rd_data),
        .dout  (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    pcmq_settle #(.DELAY(SETTLE_TICK), .NCLR(2)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ser_tick),
        .clr_req   (clr_req),
        .clr_fire  (clr_fire),
        .clr_busy  (clr_busy),
        .sync_wr   (wr_ctrl),
        .sync_din  (bus_wdata[B_SYNC]),
        .sync_echo (sync_echo)
    );

    pcmq_dreq #(.LW(LW), .TW(THR_W)) u_dreq (
        .dma_en     (dmaen_q),
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .tx_req_lvl (lvl_q[14:8]),
        .tx_pnc_lvl (lvl_q[30:24]),
        .rx_req_lvl (lvl_q[6:0]),
        .rx_pnc_lvl (lvl_q[22:16]),
        .tx_need    (tx_need),
        .rx_need    (rx_need),
        .tx_dreq    (tx_dreq),
        .tx_panic   (tx_panic),
        .rx_dreq    (rx_dreq),
        .rx_panic   (rx_panic)
    );

    // Read mux: control/status, capture head, levels.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[B_EN]    = en_q;
                bus_rdata[B_RXON]  = rxon_q;
                bus_rdata[B_TXON]  = txon_q;
                bus_rdata[B_TXCLR] = clr_busy[0];
                bus_rdata[B_RXCLR] = clr_busy[1];
                bus_rdata[B_DMAEN] = dmaen_q;
                bus_rdata[B_TXERR] = txerr_q;
                bus_rdata[B_RXERR] = rxerr_q;
                bus_rdata[B_TXW]   = tx_need;
                bus_rdata[B_RXR]   = rx_need;
                bus_rdata[B_RXD]   = !rx_empty;
                bus_rdata[B_TXE]   = tx_empty;
                bus_rdata[B_SYNC]  = sync_echo;
                bus_rdata[B_WAKE]  = wake_q;
            end
            ADDR_DATA: bus_rdata[WIDTH-1:0] = rx_head;
            ADDR_LVL:  bus_rdata = lvl_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R4
    txerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txerr_q && !(wr_ctrl && bus_wdata[B_TXERR])) |=> txerr_q);

    // R4
    rxerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxerr_q && !(wr_ctrl && bus_wdata[B_RXERR])) |=> rxerr_q);

    // R6
    dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dmaen_q |-> !(tx_dreq || tx_panic || rx_dreq || rx_panic));

    // R7
    panic_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_panic && (lvl_q[30:24] <= lvl_q[14:8])) |-> tx_dreq);

    // R10
    idle_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_live && !wr_data && !clr_fire[0]) |=> $stable(tx_level));

    // R3
    tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && wr_data && !(tx_pop && tx_live) && !clr_fire[0]) |=> tx_full);
endmodule

// File: tb/pcm_fifo_dma_test.sv
module pcm_fifo_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wr = 0, b_rd = 0;
    logic [1:0]  b_addr = 0;
    logic [31:0] b_wdata = 0;
    logic [31:0] bus_rdata;
    logic        s_tick = 0, s_pop = 0, s_push = 0;
    logic [31:0] s_rword = 0;
    logic [31:0] tx_word;
    logic        tx_dreq, tx_panic, rx_dreq, rx_panic;

    always #5 clk = ~clk;

    pcm_fifo_dma uut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr), .bus_wdata(b_wdata),
        .bus_rdata(bus_rdata), .ser_tick(s_tick), .tx_pop(s_pop),
        .tx_word(tx_word), .rx_push(s_push), .rx_word(s_rword),
        .tx_dreq(tx_dreq), .tx_panic(tx_panic), .rx_dreq(rx_dreq), .rx_panic(rx_panic)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string tag_now = "R1";

    // Reference model state
    logic [31:0] tq[$];
    logic [31:0] rq[$];
    bit m_en, m_rxon, m_txon, m_dma, m_wake, m_txerr, m_rxerr;
    int c_tx, c_rx;
    bit m_sq, m_s0, m_s1;
    logic [31:0] m_thr;
    logic [31:0] last_rdata, last_exp, last_tword;

    localparam logic [31:0] ON_ALL = 32'h0200_0207; // bits 0,1,2,9,25

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] v = '0;
        v[0] = m_en; v[1] = m_rxon; v[2] = m_txon;
        v[3] = (c_tx != 0); v[4] = (c_rx != 0);
        v[9] = m_dma; v[15] = m_txerr; v[16] = m_rxerr;
        v[17] = tq.size() < int'(m_thr[14:8]);
        v[18] = rq.size() > int'(m_thr[6:0]);
        v[20] = rq.size() != 0;
        v[21] = tq.size() == 0;
        v[24] = m_s1; v[25] = m_wake;
        return v;
    endfunction

    function automatic logic [3:0] exp_dma();
        logic [3:0] v;
        v[3] = m_dma && (tq.size() < int'(m_thr[14:8]));
        v[2] = m_dma && (tq.size() < int'(m_thr[30:24]));
        v[1] = m_dma && (rq.size() > int'(m_thr[6:0]));
        v[0] = m_dma && (rq.size() > int'(m_thr[22:16]));
        return v;
    endfunction

    task automatic model_reset();
        tq.delete(); rq.delete();
        m_en = 0; m_rxon = 0; m_txon = 0; m_dma = 0; m_wake = 0;
        m_txerr = 0; m_rxerr = 0; c_tx = 0; c_rx = 0;
        m_sq = 0; m_s0 = 0; m_s1 = 0; m_thr = 32'h1030_3020;
    endtask

    // One clock: sample mid-cycle, update model from pre-edge state, clock.
    task automatic step();
        int txn, rxn;
        bit txl, rxl, wctl, wdat, rdat, ftx, frx, rq_tx, rq_rx;
        txn = tq.size(); rxn = rq.size();
        txl = m_en && m_wake && m_txon;
        rxl = m_en && m_wake && m_rxon;
        wctl = b_wr && b_addr == 2'd0;
        wdat = b_wr && b_addr == 2'd1;
        rdat = b_rd && b_addr == 2'd1;
        rq_tx = wctl && b_wdata[3];
        rq_rx = wctl && b_wdata[4];
        #4;
        last_rdata = bus_rdata;
        last_tword = tx_word;
        case (b_addr)
            2'd0: last_exp = exp_ctrl();
            2'd1: last_exp = (rxn > 0) ? rq[0] : 32'h0;
            2'd2: last_exp = m_thr;
            default: last_exp = 32'h0;
        endcase
        if (b_rd) chk(last_rdata == last_exp, tag_now, last_rdata, last_exp);
        if (s_pop && txl && txn > 0) chk(last_tword == tq[0], "R2 tx order", last_tword, tq[0]);
        ftx = s_tick && c_tx == 1 && !rq_tx;
        frx = s_tick && c_rx == 1 && !rq_rx;
        if (s_pop && txl && txn == 0) m_txerr = 1;
        else if (wctl && b_wdata[15]) m_txerr = 0;
        if (s_push && rxl && rxn == 64) m_rxerr = 1;
        else if (wctl && b_wdata[16]) m_rxerr = 0;
        if (rq_tx) c_tx = 2; else if (s_tick && c_tx != 0) c_tx--;
        if (rq_rx) c_rx = 2; else if (s_tick && c_rx != 0) c_rx--;
        if (s_tick) begin m_s1 = m_s0; m_s0 = m_sq; end
        if (ftx) tq.delete();
        else begin
            if (s_pop && txl && txn > 0) void'(tq.pop_front());
            if (wdat && txn < 64) tq.push_back(b_wdata);
        end
        if (frx) rq.delete();
        else begin
            if (rdat && rxn > 0) void'(rq.pop_front());
            if (s_push && rxl && rxn < 64) rq.push_back(s_rword);
        end
        if (wctl) begin
            m_en = b_wdata[0]; m_rxon = b_wdata[1]; m_txon = b_wdata[2];
            m_dma = b_wdata[9]; m_wake = b_wdata[25]; m_sq = b_wdata[24];
        end
        if (b_wr && b_addr == 2'd2) m_thr = b_wdata & 32'h7F7F_7F7F;
        @(posedge clk); #1;
        b_wr = 0; b_rd = 0; b_addr = 0; b_wdata = 0;
        s_tick = 0; s_pop = 0; s_push = 0; s_rword = 0;
    endtask

    task automatic chk_dma(string tag);
        logic [3:0] act, exp;
        #2;
        act = {tx_dreq, tx_panic, rx_dreq, rx_panic};
        exp = exp_dma();
        chk(act == exp, tag, 32'(act), 32'(exp));
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d, bit tick = 0);
        b_wr = 1; b_addr = a; b_wdata = d; s_tick = tick; step();
    endtask

    task automatic rd(logic [1:0] a);
        b_rd = 1; b_addr = a; step();
    endtask

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) begin s_tick = 1; step(); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        tag_now = "R1 ctrl";
        rd(2'd0);
        chk(last_rdata == 32'h0022_0000, "R1 ctrl literal", last_rdata, 32'h0022_0000);
        tag_now = "R1 levels";
        rd(2'd2);
        chk(last_rdata == 32'h1030_3020, "R1 levels literal", last_rdata, 32'h1030_3020);
        chk_dma("R1 dma");

        // R11 level register masking and address 3
        wr(2'd2, 32'hFFFF_FFFF);
        tag_now = "R11 mask";
        rd(2'd2);
        chk(last_rdata == 32'h7F7F_7F7F, "R11 mask literal", last_rdata, 32'h7F7F_7F7F);
        tag_now = "R11 addr3";
        rd(2'd3);
        wr(2'd2, 32'h0410_0C02);
        chk_dma("R6 dma off");

        // R2/R3 playback fill past full, drain in order
        wr(2'd0, ON_ALL);
        chk_dma("R6 empty");
        for (int i = 0; i < 70; i++) begin
            wr(2'd1, 32'hA000_0000 + i);
            if (i == 3 || i == 20) chk_dma("R7 tx level");
        end
        tag_now = "R5 tx full";
        rd(2'd0);
        for (int i = 0; i < 64; i++) begin
            s_pop = 1; step();
            if (i == 0) chk(last_tword == 32'hA000_0000, "R2 first", last_tword, 32'hA000_0000);
            if (i == 63) chk(last_tword == 32'hA000_003F, "R3 last kept", last_tword, 32'hA000_003F);
            if (i == 55 || i == 61) chk_dma("R7 tx panic");
        end
        tag_now = "R3 tx drained";
        rd(2'd0);
        // R4 underflow then write-one clear
        s_pop = 1; step();
        tag_now = "R4 txerr set";
        rd(2'd0);
        chk(last_rdata[15] == 1'b1, "R4 txerr bit", 32'(last_rdata[15]), 32'h1);
        wr(2'd0, ON_ALL | 32'h0000_8000);
        tag_now = "R4 txerr clr";
        rd(2'd0);

        // R2/R3/R4 capture side
        for (int i = 0; i < 66; i++) begin
            s_push = 1; s_rword = 32'h5500_0000 + i; step();
            if (i == 1 || i == 16 || i == 30) chk_dma("R6 rx level");
        end
        tag_now = "R4 rxerr set";
        rd(2'd0);
        chk(last_rdata[16] == 1'b1, "R4 rxerr bit", 32'(last_rdata[16]), 32'h1);
        tag_now = "R2 rx order";
        for (int i = 0; i < 64; i++) rd(2'd1);
        tag_now = "R3 rx empty read";
        rd(2'd1);
        chk(last_rdata == 32'h0, "R3 zero", last_rdata, 32'h0);
        wr(2'd0, ON_ALL | 32'h0001_0000);
        tag_now = "R5 after drain";
        rd(2'd0);

        // R8 playback flush with a tick in the write cycle
        for (int i = 0; i < 5; i++) wr(2'd1, 32'hC0 + i);
        wr(2'd0, ON_ALL | 32'h0000_0008, 1'b1);
        tag_now = "R8 pending";
        rd(2'd0);
        chk(last_rdata[3] == 1'b1 && last_rdata[21] == 1'b0, "R8 busy", last_rdata, 32'h8);
        tick_n(1);
        tag_now = "R8 one tick";
        rd(2'd0);
        chk(last_rdata[21] == 1'b0, "R8 not yet", 32'(last_rdata[21]), 32'h0);
        tick_n(1);
        tag_now = "R8 done";
        rd(2'd0);
        chk(last_rdata[21] == 1'b1 && last_rdata[3] == 1'b0, "R8 flushed", last_rdata, 32'h0020_0000);
        // R8 capture flush
        for (int i = 0; i < 4; i++) begin s_push = 1; s_rword = i; step(); end
        wr(2'd0, ON_ALL | 32'h0000_0010);
        tick_n(2);
        tag_now = "R8 rx flushed";
        rd(2'd0);
        chk(last_rdata[20] == 1'b0, "R8 rx empty", 32'(last_rdata[20]), 32'h0);

        // R9 sync echo
        wr(2'd0, ON_ALL | 32'h0100_0000, 1'b1);
        tag_now = "R9 echo 0";
        rd(2'd0);
        tick_n(1);
        rd(2'd0);
        chk(last_rdata[24] == 1'b0, "R9 early", 32'(last_rdata[24]), 32'h0);
        tick_n(1);
        tag_now = "R9 echo 1";
        rd(2'd0);
        chk(last_rdata[24] == 1'b1, "R9 echo", 32'(last_rdata[24]), 32'h1);

        // R10 serial side ignored when not on / in standby
        wr(2'd1, 32'hBEEF);
        wr(2'd0, 32'h0200_0201);  // enable, wake, dma; directions off
        s_pop = 1; step();
        s_push = 1; s_rword = 32'h77; step();
        tag_now = "R10 dir off";
        rd(2'd0);
        chk(last_rdata[21] == 1'b0 && last_rdata[15] == 1'b0, "R10 tx kept", last_rdata, 32'h0);
        wr(2'd0, 32'h0000_0207);  // standby not left
        s_push = 1; s_rword = 32'h78; step();
        s_pop = 1; step();
        tag_now = "R10 standby";
        rd(2'd1);
        chk(last_rdata == 32'h0, "R10 rx none", last_rdata, 32'h0);
        wr(2'd0, ON_ALL);
        s_pop = 1; step();
        chk(last_tword == 32'hBEEF, "R10 word kept", last_tword, 32'hBEEF);

        // Random mix against the model
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6000; i++) begin
            bit heavy;
            int op;
            heavy = ((i / 400) % 2) == 0;
            op = $urandom_range(0, 9);
            if (i % 1000 == 0) begin
                b_wr = 1; b_addr = 2'd2; b_wdata = $urandom();
            end else if (i % 700 == 5) begin
                b_wr = 1; b_addr = 2'd0; b_wdata = ON_ALL | 32'h0001_8000;
            end else if (op < 4) begin
                if (heavy) begin b_wr = 1; b_addr = 2'd1; b_wdata = $urandom(); end
                else begin b_rd = 1; b_addr = 2'd1; end
            end else if (op == 4) begin
                b_rd = 1; b_addr = 2'd0;
            end else if (op == 5) begin
                b_rd = 1; b_addr = 2'($urandom_range(2, 3));
            end
            s_pop  = heavy ? ($urandom_range(0, 4) == 0) : ($urandom_range(0, 1) == 0);
            s_push = heavy ? ($urandom_range(0, 1) == 0) : ($urandom_range(0, 4) == 0);
            s_rword = $urandom();
            s_tick = $urandom_range(0, 1) == 0;
            tag_now = "R5 random read";
            step();
            chk_dma((i % 2) ? "R6 random" : "R7 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule